// File: doc/BRIEF.md
# Daisy-Chain SPI Output Latch

This block is the serial front end of an eight-channel output driver. A host drives a shared serial clock, a shared active-low chip select and a data line. Devices are linked SO-to-SI, so one three-wire port controls a whole string of drivers. While chip select is low, each device is a plain shift register. On every serial clock it takes one bit from its data input and passes its oldest bit on to the next device. Surplus bits therefore walk down the chain, and the bits sent first end up in the device farthest from the host.

When chip select returns high, each device checks how many serial clocks it saw. The frame counts as accepted only when that number is a whole, nonzero multiple of eight. An accepted frame is copied into the eight output latches. A rejected frame leaves the latches alone. After four rejected frames in a row, all channels are forced off. They stay off until an accepted frame arrives.

All three serial pins are brought into the system clock through two-flop synchronizers, and their edges are detected there. The serial clock must therefore be slow compared with the system clock. The data output has a separate enable pin that the pad uses as a tristate control.

Top module: `spi_chain_latch`

## Requirements
- R1: After the asynchronous active-low reset, all eight channel outputs are 0 and the data-output enable is 0.
- R2: While chip select is high, serial clock pulses and data input values change neither the shift register nor the outputs. An 8-bit frame sent afterwards pushes out, toward the next device, exactly the byte held before the pulses.
- R3: The data-output enable is 1 while the synchronized chip select is low and 0 while it is high (output in high impedance).
- R4: Bits are shifted MSB first: each serial clock rising edge samples the data input. The bit leaving the register is presented on the data output after the following falling edge. In a two-device chain fed a 16-bit frame, the first byte sent lands in the second device and the last byte in the first.
- R5: The channel outputs change only after chip select rises, never during a transfer. They take the shift register contents when the serial clock count of the frame is a nonzero multiple of 8 (8, 16, 24, ...).
- R6: A frame whose clock count is not a multiple of 8 (for example 12) is rejected and leaves the channel outputs unchanged.
- R7: A frame with zero serial clocks between chip select falling and rising is rejected.
- R8: The count of consecutive rejected frames saturates at 4. On reaching 4, all channel outputs read 0. Three consecutive rejects do not blank the outputs.
- R9: An accepted frame clears the reject count and restores the outputs to the newly received data. After that, three further rejects do not blank the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic and synchronizers run on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host, asynchronous |
| csn_i | input | 1 | Active-low chip select, shared by the chain |
| sdi_i | input | 1 | Serial data in, from the host or the previous device |
| sdo_o | output | 1 | Serial data out, to the next device |
| sdo_oe_o | output | 1 | Enable for the data-output pad buffer; 0 means high impedance |
| drive_o | output | 8 | Channel on/off commands, bit 7 = first bit of the device's byte |

## Verification
A fault in the shift register shows up at the next device's data input within one serial clock period. In a chain it shows up in the second device's latched byte once chip select rises. A wrong bit counter shows up on the very next chip select rise, because a frame is then accepted or rejected in the wrong case. A failure counter that is off by one shows up only on the fourth reject: the outputs blank a frame early or a frame late. That is why the bench drives runs of exactly three and four rejects. Channel outputs settle four system clocks after chip select rises, so every comparison is made well after that.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
  // channel count of one device, also the frame length in bits
  localparam int unsigned CHANNELS   = 8;
  // consecutive rejected frames that blank all channels
  localparam int unsigned REJECT_MAX = 4;
  // synchronizer depth for the asynchronous serial pins
  localparam int unsigned SYNC_DEPTH = 2;

  // synchronized serial pin levels
  typedef struct packed {
    logic sclk;
    logic csn;
    logic sdi;
  } serial_pins_t;
endpackage

// File: rtl/sce_sync.sv
module sce_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned DEPTH   = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      logic [DEPTH-1:0] stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= {DEPTH{INIT[g]}};
        else        stage_q <= {stage_q[DEPTH-2:0], async_i[g]};
      end
      assign sync_o[g] = stage_q[DEPTH-1];
    end
  endgenerate

  initial begin
    a_depth_ok: assert (DEPTH >= 2);
  end
endmodule

// File: rtl/sce_shifter.sv
module sce_shifter #(
  parameter int unsigned CH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_low,
  input  logic            cs_fall,
  input  logic            sclk_rise,
  input  logic            sclk_fall,
  input  logic            sdi,
  output logic [CH_W-1:0] shreg_o,
  output logic            sdo_o,
  output logic            frame_ok_o
);
  localparam int unsigned CNT_W = (CH_W > 1) ? $clog2(CH_W) : 1;

  logic [CH_W-1:0]  shreg_q;
  logic             sdo_q;
  logic [CNT_W-1:0] phase_q;
  logic             seen_q;
  logic             shift_en;

  assign shift_en = cs_low && sclk_rise;

  // shift register, MSB first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shreg_q <= '0;
    else if (shift_en) shreg_q <= {shreg_q[CH_W-2:0], sdi};
  end

  // outgoing bit is refreshed on the serial clock falling edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          sdo_q <= 1'b0;
    else if (cs_fall)                    sdo_q <= shreg_q[CH_W-1];
    else if (cs_low && sclk_fall)        sdo_q <= shreg_q[CH_W-1];
  end

  // modulo-CH_W bit counter plus a "clocks seen" flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      seen_q  <= 1'b0;
    end else if (cs_fall) begin
      phase_q <= '0;
      seen_q  <= 1'b0;
    end else if (shift_en) begin
      seen_q  <= 1'b1;
      if (phase_q == CNT_W'(CH_W - 1)) phase_q <= '0;
      else                             phase_q <= phase_q + 1'b1;
    end
  end

  assign frame_ok_o = seen_q && (phase_q == '0);
  assign shreg_o    = shreg_q;
  assign sdo_o      = sdo_q;

  // R2: register frozen while deselected
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_low |=> $stable(shreg_q));

  // R4: outgoing bit moves only after a falling serial clock or select
  p_sdo_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_q) |-> $past(sclk_fall || cs_fall));
endmodule

// File: rtl/sce_latch.sv
module sce_latch #(
  parameter int unsigned CH_W    = 8,
  parameter int unsigned REJ_MAX = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_rise,
  input  logic            frame_ok,
  input  logic [CH_W-1:0] shreg,
  output logic [CH_W-1:0] drive_o
);
  localparam int unsigned REJ_W = $clog2(REJ_MAX + 1);

  logic [CH_W-1:0]  latch_q;
  logic [REJ_W-1:0] rej_q;
  logic             blank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      rej_q   <= '0;
    end else if (cs_rise) begin
      if (frame_ok) begin
        latch_q <= shreg;
        rej_q   <= '0;
      end else if (rej_q != REJ_W'(REJ_MAX)) begin
        rej_q   <= rej_q + 1'b1;
      end
    end
  end

  assign blank   = (rej_q == REJ_W'(REJ_MAX));
  assign drive_o = blank ? '0 : latch_q;

  // R5: latch only changes after an accepted frame end
  p_update_on_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(latch_q) |-> $past(cs_rise && frame_ok));

  // R6: a rejected frame advances the count when below the limit
  p_reject_counts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !frame_ok && (rej_q < REJ_W'(REJ_MAX))) |=> (rej_q == $past(rej_q) + 1'b1));

  // R8: count never passes the limit
  p_reject_saturates_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rej_q <= REJ_W'(REJ_MAX));

  // R9: acceptance clears the count
  p_accept_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && frame_ok) |=> (rej_q == '0));
endmodule

// File: rtl/spi_chain_latch.sv
module spi_chain_latch
  import spi_chain_pkg::*;
#(
  parameter int unsigned CH_W    = CHANNELS,
  parameter int unsigned REJ_MAX = REJECT_MAX,
  parameter int unsigned SYNC_N  = SYNC_DEPTH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclk_i,
  input  logic            csn_i,
  input  logic            sdi_i,
  output logic            sdo_o,
  output logic            sdo_oe_o,
  output logic [CH_W-1:0] drive_o
);
  serial_pins_t pins_raw, pins_s;
  logic         sclk_d, csn_d;
  logic         sclk_rise, sclk_fall, cs_rise, cs_fall, cs_low;
  logic [CH_W-1:0] shreg;
  logic         frame_ok;

  assign pins_raw = '{sclk: sclk_i, csn: csn_i, sdi: sdi_i};

  sce_sync #(
    .WIDTH (3),
    .DEPTH (SYNC_N),
    .INIT  (3'b010)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pins_raw),
    .sync_o  (pins_s)
  );

  // edge detection in the system clock domain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sclk_d <= pins_s.sclk;
      csn_d  <= pins_s.csn;
    end
  end

  assign sclk_rise = pins_s.sclk & ~sclk_d;
  assign sclk_fall = ~pins_s.sclk & sclk_d;
  assign cs_rise   = pins_s.csn & ~csn_d;
  assign cs_fall   = ~pins_s.csn & csn_d;
  assign cs_low    = ~pins_s.csn;

  sce_shifter #(.CH_W(CH_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_low     (cs_low),
    .cs_fall    (cs_fall),
    .sclk_rise  (sclk_rise),
    .sclk_fall  (sclk_fall),
    .sdi        (pins_s.sdi),
    .shreg_o    (shreg),
    .sdo_o      (sdo_o),
    .frame_ok_o (frame_ok)
  );

  sce_latch #(.CH_W(CH_W), .REJ_MAX(REJ_MAX)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_rise  (cs_rise),
    .frame_ok (frame_ok),
    .shreg    (shreg),
    .drive_o  (drive_o)
  );

  assign sdo_oe_o = cs_low;

  // R3: no output drive across a deselected cycle pair
  p_oe_off_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_s.csn && csn_d) |-> !sdo_oe_o);

  // R5: channels hold steady while a transfer is open
  p_hold_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_low |=> $stable(drive_o));
endmodule

// File: tb/spi_chain_latch_tb_top.sv
module spi_chain_latch_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, sdi = 1'b0;
  logic link, sdo_b, oe_a, oe_b;
  logic [7:0] drv_a, drv_b;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // host-side model of both devices
  logic [7:0] m_sr_a = '0, m_sr_b = '0, m_lat_a = '0, m_lat_b = '0;
  int m_rej = 0;

  typedef struct {
    logic [7:0] exp_a;
    logic [7:0] exp_b;
    int         due;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_chain_latch dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi),
    .sdo_o(link), .sdo_oe_o(oe_a), .drive_o(drv_a)
  );

  spi_chain_latch dut_b_i (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .sdi_i(link),
    .sdo_o(sdo_b), .sdo_oe_o(oe_b), .drive_o(drv_b)
  );

  task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_expect(input string tag);
    exp_t e;
    e.exp_a = (m_rej >= 4) ? 8'h00 : m_lat_a;
    e.exp_b = (m_rej >= 4) ? 8'h00 : m_lat_b;
    e.due   = cyc + 12;
    e.tag   = tag;
    sb_q.push_back(e);
  endtask

  // driver: one frame of nbits, MSB of the field first
  task automatic send_frame(input logic [31:0] data, input int nbits, input string tag);
    logic [7:0] pre_a, pre_b;
    pre_a = drv_a;
    pre_b = drv_b;
    csn = 1'b0;
    wait_clk(8);
    chk(oe_a == 1'b1, "R3", {7'b0, oe_a}, 8'h01);
    for (int i = 0; i < nbits; i++) begin
      logic b;
      b = data[nbits-1-i];
      sdi = b;
      m_sr_b = {m_sr_b[6:0], m_sr_a[7]};
      m_sr_a = {m_sr_a[6:0], b};
      wait_clk(8);
      sclk = 1'b1;
      wait_clk(8);
      sclk = 1'b0;
      wait_clk(8);
    end
    // R5: nothing moves before chip select rises
    chk(drv_a == pre_a, "R5", drv_a, pre_a);
    chk(drv_b == pre_b, "R5", drv_b, pre_b);
    csn = 1'b1;
    if (nbits > 0 && (nbits % 8) == 0) begin
      m_lat_a = m_sr_a;
      m_lat_b = m_sr_b;
      m_rej = 0;
    end else if (m_rej < 4) begin
      m_rej++;
    end
    push_expect(tag);
    wait_clk(20);
  endtask

  // monitor: compare channel outputs once each expectation is due
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0 && cyc >= sb_q[0].due) begin
        exp_t e;
        e = sb_q.pop_front();
        chk(drv_a == e.exp_a, e.tag, drv_a, e.exp_a);
        chk(drv_b == e.exp_b, e.tag, drv_b, e.exp_b);
      end
    end
  end

  initial begin
    wait_clk(3);
    // R1: reset state
    chk(drv_a == 8'h00, "R1", drv_a, 8'h00);
    chk(drv_b == 8'h00, "R1", drv_b, 8'h00);
    chk(oe_a == 1'b0, "R1", {7'b0, oe_a}, 8'h00);
    rst_n = 1'b1;
    wait_clk(5);

    // R4 and R5: 16-bit frame, first byte reaches the far device
    send_frame(32'h0000_A53C, 16, "R4");
    // R3: deselected means no drive
    chk(oe_a == 1'b0, "R3", {7'b0, oe_a}, 8'h00);
    chk(oe_b == 1'b0, "R3", {7'b0, oe_b}, 8'h00);

    // R2: serial clocks with chip select high are ignored
    sdi = 1'b1;
    for (int i = 0; i < 12; i++) begin
      wait_clk(8); sclk = 1'b1; wait_clk(8); sclk = 1'b0;
    end
    wait_clk(10);
    chk(drv_a == m_lat_a, "R2", drv_a, m_lat_a);
    chk(oe_a == 1'b0, "R2", {7'b0, oe_a}, 8'h00);
    // 8-bit frame: device B receives A's old byte (3C), not ones
    send_frame(32'h0000_0081, 8, "R2");

    // R6: 12-bit frame rejected
    send_frame(32'h0000_0F0F, 12, "R6");
    // R7: empty frame rejected
    send_frame(32'h0, 0, "R7");
    // R8: third reject keeps outputs, fourth blanks
    send_frame(32'h0000_0055, 5, "R8");
    send_frame(32'h0000_0003, 3, "R8");
    send_frame(32'h0000_0001, 1, "R8");
    // R9: accepted frame restores, then three rejects do not blank
    send_frame(32'h0000_6699, 16, "R9");
    send_frame(32'h0000_0007, 3, "R9");
    send_frame(32'h0000_0007, 3, "R9");
    send_frame(32'h0000_0007, 3, "R9");
    // R5: 24-bit frame is a multiple of 8 as well
    send_frame(32'h00C3_5AF0, 24, "R5");

    wait_clk(30);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // watchdog
  initial begin
    wait (cyc >= 100000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule